// File: doc/BRIEF.md
# MMU Fault Status Generator

This block sits after the translation lookup of a processor's memory unit. For each access it receives the access kind (load, store or instruction fetch), the virtual address and the lookup result. The lookup result is a hit flag, a protection-versus-miss flag, and the matching entry's virtual base, physical base and permission bits. The translation table itself lives outside the block and is presented as plain inputs.

When the memory unit is configured present and the processor's virtual-mode bit is set, a hit produces a page-aligned physical address and the entry's permissions. A failed lookup does three things: it latches the faulting address, it encodes a fault status code, and it raises an exception request that stays up until the core acknowledges it. When translation is off, the page address is returned unchanged with every permission granted. A second fault that arrives while an exception request is still pending is a fatal condition. It is reported on a sticky flag, and from then until reset the block accepts no further fault.

Top module: `mmu_fault_status`

## Requirements
- R1: During and right after a synchronous active-low reset, xl_valid, mmu_exc_req, recursive_fault, ear and esr are all zero.
- R2: If mmu_present is 0 or vm_en is 0, an access with acc_valid=1 gives, one cycle later, xl_valid=1, xl_paddr equal to vaddr with bits 11:0 cleared, and xl_perm all ones. No fault is raised, and ear and esr keep their values.
- R3: With translation on and tlb_hit=1, one cycle later xl_valid=1, xl_paddr = (tlb_pbase + ((vaddr & ~0xFFF) - tlb_vbase)) with bits 11:0 cleared (modulo 2^32), and xl_perm = tlb_perm.
- R4: A failed lookup (translation on, tlb_hit=0) that is accepted loads the full 32-bit vaddr into ear one cycle later. In that cycle xl_valid is 0.
- R5: A protection failure (tlb_prot_err=1) gives esr[4:0]=17 for an instruction fetch (acc_type=2). It gives 16 for a data access (acc_type 0 = load, 1 = store; 3 is treated as a load).
- R6: A miss (tlb_prot_err=0) gives esr[4:0]=19 for an instruction fetch and 18 for a data access.
- R7: esr bit 10 is 1 exactly when the accepted fault was a store (acc_type=1). All other esr bits are 0.
- R8: An accepted fault sets mmu_exc_req one cycle later. It stays set until a cycle in which exc_ack=1, after which it reads 0.
- R9: A fault that arrives while mmu_exc_req is 1 sets recursive_fault, including when exc_ack is high in the same cycle. It does not change ear or esr.
- R10: Once recursive_fault is 1, it stays 1 until reset. Faults then update neither ear nor esr and never raise mmu_exc_req.
- R11: In a cycle with acc_valid=0 the next xl_valid is 0, and ear, esr and the fault state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_type | input | 2 | 0 load, 1 store, 2 instruction fetch, 3 treated as load |
| vaddr | input | 32 | Virtual address of the access |
| vm_en | input | 1 | Virtual-mode bit from the machine status |
| mmu_present | input | 1 | Configuration: memory unit present |
| tlb_hit | input | 1 | Lookup found a usable entry |
| tlb_prot_err | input | 1 | On a failed lookup: 1 protection, 0 miss |
| tlb_vbase | input | 32 | Virtual base of the hit entry |
| tlb_pbase | input | 32 | Physical base of the hit entry |
| tlb_perm | input | 3 | Permission bits of the hit entry |
| exc_ack | input | 1 | Core has entered the exception; clears the request |
| xl_valid | output | 1 | Registered translation result is valid |
| xl_paddr | output | 32 | Page-aligned physical address |
| xl_perm | output | 3 | Permissions of the translated page |
| ear | output | 32 | Latched faulting virtual address |
| esr | output | 16 | Fault status code |
| mmu_exc_req | output | 1 | Memory-unit exception request |
| recursive_fault | output | 1 | Sticky: fault taken while a request was pending |

## Verification
The hardest case to reach is the recursive fault. It needs a second failed lookup in one of the few cycles before the core acknowledges the first, and it is sharpest when the acknowledge and the new fault land on the same edge. Directed sequences create exactly that overlap, then confirm that ear and esr still hold the first fault and that later faults raise nothing. Random stimulus makes lookups fail often and acknowledges only about half the time, so both overlapping and separated faults occur. The bench applies a reset every few hundred accesses so that the sticky state does not hide the rest of the behaviour.

// File: rtl/mmufs_pkg.sv
// Shared types and status code constants for the MMU fault status generator.
// Assumes the access kind arrives as a 2-bit code; the reserved code acts as a load.
package mmufs_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    localparam logic [4:0] CODE_PROT_DATA  = 5'd16;
    localparam logic [4:0] CODE_PROT_FETCH = 5'd17;
    localparam logic [4:0] CODE_MISS_DATA  = 5'd18;
    localparam logic [4:0] CODE_MISS_FETCH = 5'd19;
    localparam int unsigned STORE_BIT_POS  = 10;

endpackage

// File: rtl/mmufs_xlate.sv
// Combinational translation stage: decides bypass, hit or fault for one access
// and forms the page-aligned physical address and permissions.
// Assumes the entry's bases are page aligned; low bits are masked regardless.
module mmufs_xlate #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PERM_W    = 3
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              vm_en,
    input  logic              mmu_present,
    input  logic              tlb_hit,
    input  logic [ADDR_W-1:0] tlb_vbase,
    input  logic [ADDR_W-1:0] tlb_pbase,
    input  logic [PERM_W-1:0] tlb_perm,
    output logic              ok,
    output logic              fault,
    output logic [ADDR_W-1:0] paddr,
    output logic [PERM_W-1:0] perm
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W)'((64'd1 << PAGE_BITS) - 64'd1));

    logic              xl_on;
    logic [ADDR_W-1:0] vpage;
    logic [ADDR_W-1:0] mapped;

    // Translation applies only with the unit present and virtual mode on.
    always_comb begin
        xl_on  = mmu_present & vm_en;
        vpage  = vaddr & PAGE_MASK;
        mapped = (tlb_pbase + (vpage - tlb_vbase)) & PAGE_MASK;
    end

    // Select bypass, hit or fault result.
    always_comb begin
        ok    = 1'b0;
        fault = 1'b0;
        paddr = vpage;
        perm  = '1;
        if (acc_valid) begin
            if (!xl_on) begin
                ok = 1'b1;
            end else if (tlb_hit) begin
                ok    = 1'b1;
                paddr = mapped;
                perm  = tlb_perm;
            end else begin
                fault = 1'b1;
            end
        end
    end

    // Guard: an access is never both translated and faulted (R3, R4).
    always_comb begin
        assert_ok_fault_excl_R4: assert (!(ok && fault));
    end
endmodule

// File: rtl/mmufs_code.sv
// Status code encoder: maps fault kind and access kind to the fixed code
// with the store flag placed in its own bit. Assumes ESR_W > STORE_BIT_POS.
module mmufs_code
    import mmufs_pkg::*;
#(
    parameter int unsigned ESR_W = 16
) (
    input  logic [1:0]       acc_type,
    input  logic             is_prot,
    output logic [ESR_W-1:0] code
);
    acc_e kind;
    logic [4:0] base;

    // Pick the base code from fault kind and fetch-versus-data.
    always_comb begin
        kind = acc_e'(acc_type);
        if (is_prot) base = (kind == ACC_FETCH) ? CODE_PROT_FETCH : CODE_PROT_DATA;
        else         base = (kind == ACC_FETCH) ? CODE_MISS_FETCH : CODE_MISS_DATA;
    end

    // Assemble the full-width code with the store flag.
    always_comb begin
        code = '0;
        code[4:0] = base;
        code[STORE_BIT_POS] = (kind == ACC_STORE);
    end

    // Guard: base code always within the fault code range (R5, R6).
    always_comb begin
        assert_code_range_R5: assert (base >= 5'd16 && base <= 5'd19);
    end
endmodule

// File: rtl/mmufs_state.sv
// Fault state: latches the faulting address and code, holds the exception
// request until acknowledged, and keeps the sticky recursive-fault flag.
// Assumes fault is a single-cycle qualifier from the translation stage.
module mmufs_state #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ESR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic [ESR_W-1:0]  fault_code,
    input  logic              exc_ack,
    output logic [ADDR_W-1:0] ear,
    output logic [ESR_W-1:0]  esr,
    output logic              req,
    output logic              recur
);
    logic take;

    // A fault is taken only with no request pending and no recursion seen.
    always_comb take = fault && !req && !recur;

    // Exception address and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ear <= '0;
            esr <= '0;
        end else if (take) begin
            ear <= fault_addr;
            esr <= fault_code;
        end
    end

    // Exception request: set on a taken fault, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       req <= 1'b0;
        else if (take)    req <= 1'b1;
        else if (exc_ack) req <= 1'b0;
    end

    // Sticky recursive-fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                  recur <= 1'b0;
        else if (fault && req)       recur <= 1'b1;
    end

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req && !exc_ack |=> req);
    assert_recur_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recur |=> recur);
    assert_no_req_after_recur_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recur && !req |=> !req);
    assert_ear_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |=> $stable(ear) && $stable(esr));
    assert_recur_keeps_ear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault && req |=> $stable(ear));
endmodule

// File: rtl/mmu_fault_status.sv
// MMU fault status generator top: registers the translation result and
// feeds failed lookups to the fault state with an encoded status code.
// Assumes the lookup inputs are valid in the same cycle as acc_valid.
module mmu_fault_status #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned PAGE_BITS = 12,
    parameter int unsigned PERM_W    = 3,
    parameter int unsigned ESR_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [1:0]        acc_type,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              vm_en,
    input  logic              mmu_present,
    input  logic              tlb_hit,
    input  logic              tlb_prot_err,
    input  logic [ADDR_W-1:0] tlb_vbase,
    input  logic [ADDR_W-1:0] tlb_pbase,
    input  logic [PERM_W-1:0] tlb_perm,
    input  logic              exc_ack,
    output logic              xl_valid,
    output logic [ADDR_W-1:0] xl_paddr,
    output logic [PERM_W-1:0] xl_perm,
    output logic [ADDR_W-1:0] ear,
    output logic [ESR_W-1:0]  esr,
    output logic              mmu_exc_req,
    output logic              recursive_fault
);
    logic              ok_c;
    logic              fault_c;
    logic [ADDR_W-1:0] paddr_c;
    logic [PERM_W-1:0] perm_c;
    logic [ESR_W-1:0]  code_c;

    mmufs_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .PERM_W(PERM_W)) u_xlate (
        .acc_valid   (acc_valid),
        .vaddr       (vaddr),
        .vm_en       (vm_en),
        .mmu_present (mmu_present),
        .tlb_hit     (tlb_hit),
        .tlb_vbase   (tlb_vbase),
        .tlb_pbase   (tlb_pbase),
        .tlb_perm    (tlb_perm),
        .ok          (ok_c),
        .fault       (fault_c),
        .paddr       (paddr_c),
        .perm        (perm_c)
    );

    mmufs_code #(.ESR_W(ESR_W)) u_code (
        .acc_type (acc_type),
        .is_prot  (tlb_prot_err),
        .code     (code_c)
    );

    mmufs_state #(.ADDR_W(ADDR_W), .ESR_W(ESR_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault      (fault_c),
        .fault_addr (vaddr),
        .fault_code (code_c),
        .exc_ack    (exc_ack),
        .ear        (ear),
        .esr        (esr),
        .req        (mmu_exc_req),
        .recur      (recursive_fault)
    );

    // Register the translation result for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid <= 1'b0;
            xl_paddr <= '0;
            xl_perm  <= '0;
        end else begin
            xl_valid <= ok_c;
            if (ok_c) begin
                xl_paddr <= paddr_c;
                xl_perm  <= perm_c;
            end
        end
    end

    assert_bypass_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !(vm_en && mmu_present) |=> xl_valid && (&xl_perm));
    assert_idle_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !xl_valid);
    assert_fault_raises_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && vm_en && mmu_present && !tlb_hit && !mmu_exc_req && !recursive_fault
        |=> mmu_exc_req && !xl_valid);
endmodule

// File: tb/mmu_fault_status_tb.sv
module mmu_fault_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_type = 2'd0;
    logic [31:0] vaddr = '0;
    logic        vm_en = 1'b0;
    logic        mmu_present = 1'b0;
    logic        tlb_hit = 1'b0;
    logic        tlb_prot_err = 1'b0;
    logic [31:0] tlb_vbase = '0;
    logic [31:0] tlb_pbase = '0;
    logic [2:0]  tlb_perm = '0;
    logic        exc_ack = 1'b0;
    logic        xl_valid;
    logic [31:0] xl_paddr;
    logic [2:0]  xl_perm;
    logic [31:0] ear;
    logic [15:0] esr;
    logic        mmu_exc_req;
    logic        recursive_fault;

    int checks = 0;
    int errors = 0;

    // model state
    logic        m_valid;
    logic [31:0] m_paddr;
    logic [2:0]  m_perm;
    logic [31:0] m_ear;
    logic [15:0] m_esr;
    logic        m_req;
    logic        m_recur;

    always #4 clk = ~clk;

    mmu_fault_status u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
        .vaddr(vaddr), .vm_en(vm_en), .mmu_present(mmu_present), .tlb_hit(tlb_hit),
        .tlb_prot_err(tlb_prot_err), .tlb_vbase(tlb_vbase), .tlb_pbase(tlb_pbase),
        .tlb_perm(tlb_perm), .exc_ack(exc_ack), .xl_valid(xl_valid), .xl_paddr(xl_paddr),
        .xl_perm(xl_perm), .ear(ear), .esr(esr), .mmu_exc_req(mmu_exc_req),
        .recursive_fault(recursive_fault)
    );

    function automatic logic [15:0] exp_code(input logic [1:0] t, input logic prot);
        logic [15:0] c;
        c = '0;
        if (prot) c[4:0] = (t == 2'd2) ? 5'd17 : 5'd16;
        else      c[4:0] = (t == 2'd2) ? 5'd19 : 5'd18;
        c[10] = (t == 2'd1);
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare();
        chk(xl_valid == m_valid, "R2/R3/R11 xl_valid", 32'(xl_valid), 32'(m_valid));
        if (m_valid) begin
            chk(xl_paddr == m_paddr, "R2/R3 xl_paddr", xl_paddr, m_paddr);
            chk(xl_perm == m_perm, "R2/R3 xl_perm", 32'(xl_perm), 32'(m_perm));
        end
        chk(ear == m_ear, "R4/R9/R10 ear", ear, m_ear);
        chk(esr == m_esr, "R5/R6/R7 esr", 32'(esr), 32'(m_esr));
        chk(mmu_exc_req == m_req, "R8 mmu_exc_req", 32'(mmu_exc_req), 32'(m_req));
        chk(recursive_fault == m_recur, "R9/R10 recursive_fault", 32'(recursive_fault), 32'(m_recur));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        exc_ack = 1'b0;
        @(posedge clk); #1;
        m_valid = 0; m_paddr = '0; m_perm = '0; m_ear = '0; m_esr = '0; m_req = 0; m_recur = 0;
        chk(xl_valid == 0 && mmu_exc_req == 0 && recursive_fault == 0 && ear == 0 && esr == 0,
            "R1 reset state", {ear[15:0], esr}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // apply one access at negedge, step one edge, update model, compare
    task automatic step(input logic v, input logic [1:0] t, input logic [31:0] a,
                        input logic vm, input logic pr, input logic hit, input logic prot,
                        input logic [31:0] vb, input logic [31:0] pb, input logic [2:0] pm,
                        input logic ack);
        logic fault;
        logic [31:0] pg;
        @(negedge clk);
        acc_valid = v; acc_type = t; vaddr = a; vm_en = vm; mmu_present = pr;
        tlb_hit = hit; tlb_prot_err = prot; tlb_vbase = vb; tlb_pbase = pb;
        tlb_perm = pm; exc_ack = ack;
        @(posedge clk); #1;
        pg = a & 32'hFFFF_F000;
        fault = 0;
        m_valid = 0;
        if (v) begin
            if (!(vm && pr)) begin
                m_valid = 1; m_paddr = pg; m_perm = 3'b111;
            end else if (hit) begin
                m_valid = 1; m_paddr = (pb + (pg - vb)) & 32'hFFFF_F000; m_perm = pm;
            end else fault = 1;
        end
        if (fault && m_req) m_recur = 1;
        if (fault && !m_req && !m_recur) begin
            m_ear = a; m_esr = exp_code(t, prot); m_req = 1;
        end else if (ack) m_req = 0;
        // m_recur update above uses pre-edge m_req, done before req change
        compare();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R2 bypass: unit absent, and vm off
        step(1, 2'd0, 32'h1234_5678, 1, 0, 0, 0, 0, 0, 3'b000, 0);
        step(1, 2'd1, 32'hDEAD_BEEF, 0, 1, 0, 1, 0, 0, 3'b000, 0);
        // R3 hit with offset
        step(1, 2'd0, 32'h0040_3ABC, 1, 1, 1, 0, 32'h0040_0000, 32'h8000_0000, 3'b101, 0);
        // R11 idle
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 0);
        // R5 prot fetch, R8 hold, then ack
        step(1, 2'd2, 32'hC000_0123, 1, 1, 0, 1, 0, 0, 3'b000, 0);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 0);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        // R6/R7 miss store
        step(1, 2'd1, 32'h0000_0FFF, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        // R5 prot load, R6 miss fetch, R5/R7 prot store, R6 miss reserved type
        step(1, 2'd0, 32'h1111_2222, 1, 1, 0, 1, 0, 0, 3'b000, 0);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        step(1, 2'd2, 32'h3333_4444, 1, 1, 0, 0, 0, 0, 3'b000, 0);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        step(1, 2'd1, 32'h5555_6666, 1, 1, 0, 1, 0, 0, 3'b000, 0);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        step(1, 2'd3, 32'h7777_8888, 1, 1, 0, 0, 0, 0, 3'b000, 0);
        // R9: second fault with ack on the same edge
        step(1, 2'd2, 32'h9999_AAAA, 1, 1, 0, 1, 0, 0, 3'b000, 1);
        // R10: later faults ignored
        step(1, 2'd1, 32'hBBBB_CCCC, 1, 1, 0, 0, 0, 0, 3'b000, 0);
        step(0, 2'd0, 32'h0, 1, 1, 0, 0, 0, 0, 3'b000, 1);
        step(1, 2'd0, 32'hEEEE_0000, 1, 1, 0, 1, 0, 0, 3'b000, 0);
        // R1 again
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] vb;
            if (i % 250 == 249) do_reset();
            a  = $urandom;
            vb = (a & 32'hFFFF_F000) - (32'($urandom_range(0, 7)) << 12);
            step(($urandom_range(0, 5) != 0), 2'($urandom_range(0, 3)), a,
                 ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
                 ($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
                 vb, $urandom & 32'hFFFF_F000, 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule